// File: doc/BRIEF.md
# Hypervisor profiling control register

This block holds the hypervisor-level control word for statistical profiling. It is a 64-bit register. Seven bits are implemented: a timestamp select, a timestamp enable, a physical-address collect enable, a context-ID collect enable, and sampling enables for the hypervisor and user levels. Software writes the whole word through a write-enable and a data bus. Bits that are not implemented are dropped on the way in and always read as zero.

The profiling logic does not use the stored bits directly. It uses a set of effective controls. The block derives them from the stored bits and a handful of configuration inputs:

- whether the hypervisor level is present,
- whether it is enabled in the current security state,
- a two-bit buffer-owner selector,
- a host-mode flag.

Depending on these inputs, a field may be forced to a fixed value or ignored. A direct read still returns the stored bits. The one exception is the two sampling enables: they read as zero while the buffer-owner selector is non-zero. The extended-counter feature is a build parameter. Without it, the timestamp select shrinks to one bit.

Top module: `hyp_prof_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stored bits clear to zero and any write is discarded, so `rd_data` is 0 after reset.
- R2: Field positions are: bit 0 user sampling enable, bit 1 hypervisor sampling enable, bit 3 context-ID enable, bit 4 physical-address enable, bit 5 timestamp enable, bits 7:6 timestamp select. Bit 2 and bits 63:8 always read 0, whatever is written.
- R3: A write with `wr_en` high is stored at the next rising edge, and `rd_data` and the effective outputs reflect it from that edge on. Before that edge the old value is still visible. `rd_data` returns the stored bits, not the effective values.
- R4: When `EXT_COUNTER` is 0, bit 7 is not stored, reads as 0, and `eff_tsel[1]` is 0.
- R5: When the hypervisor level is unavailable (`cfg_hyp_present` low, or `cfg_hyp_enabled` low), `eff_tsel` is 2'b01 whatever is stored. A read still returns the stored select.
- R6: When the hypervisor level is unavailable, `eff_pa_en` is 1 and `eff_cx_en` is 0.
- R7: When the hypervisor level is available:
  - `eff_tsel` follows the stored select;
  - `eff_pa_en` and `eff_cx_en` follow bits 4 and 3;
  - `eff_ts_en` follows bit 5 in every configuration.
- R8: While `cfg_buf_owner` is non-zero, `rd_data[1:0]` reads 0, and `eff_hyp_samp` and `eff_usr_samp` are 0. The stored bits come back once the selector returns to 0.
- R9: When the hypervisor level is available and `cfg_host_mode` is 0, `eff_usr_samp` is 0. Otherwise, with the owner selector at 0, `eff_usr_samp` follows bit 0.
- R10: When the hypervisor level is unavailable, `eff_hyp_samp` is 0. Otherwise, with the owner selector at 0, it follows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Word to store; unimplemented bits dropped |
| cfg_hyp_present | input | 1 | Hypervisor level is implemented |
| cfg_hyp_enabled | input | 1 | Hypervisor level is enabled in the current security state |
| cfg_buf_owner | input | 2 | Buffer-owner selector; non-zero blanks both sampling enables |
| cfg_host_mode | input | 1 | Host mode; when low with hypervisor available, user sampling is ignored |
| rd_data | output | 64 | Direct read view of the stored word |
| eff_tsel | output | 2 | Effective timestamp select |
| eff_ts_en | output | 1 | Effective timestamp enable |
| eff_pa_en | output | 1 | Effective physical-address collect enable |
| eff_cx_en | output | 1 | Effective context-ID collect enable |
| eff_hyp_samp | output | 1 | Effective hypervisor-level sampling enable |
| eff_usr_samp | output | 1 | Effective user-level sampling enable |

## Verification
The configuration inputs may take any combination and may change on any cycle. The effective outputs are combinational from them, so the forcing assertions hold within each cycle. The write assertion checks only bits 7:2 one edge after a strobe, because bits 1:0 on the read view also depend on the owner selector at that moment. The stimulus writes every low-byte value with non-zero junk above it. After each write it walks all 32 configuration combinations, one per falling edge, on a build with the extended counter and on one without.

// File: rtl/hyp_prof_pkg.sv
// Shared field positions, effective-control type and the implemented-bit
// mask for the hypervisor profiling control register.
package hyp_prof_pkg;

    localparam int BIT_USR     = 0;
    localparam int BIT_HYP     = 1;
    localparam int BIT_CX      = 3;
    localparam int BIT_PA      = 4;
    localparam int BIT_TS      = 5;
    localparam int BIT_TSEL_LO = 6;
    localparam int BIT_TSEL_HI = 7;

    localparam logic [1:0] TSEL_PHYSICAL = 2'b01;

    typedef struct packed {
        logic [1:0] tsel;
        logic       ts_en;
        logic       pa_en;
        logic       cx_en;
        logic       hyp_samp;
        logic       usr_samp;
    } prof_eff_t;

    // Mask of stored bits; bit 7 exists only with the extended counter.
    function automatic logic [63:0] impl_mask(input bit ext);
        logic [63:0] m;
        m = '0;
        m[BIT_USR]     = 1'b1;
        m[BIT_HYP]     = 1'b1;
        m[BIT_CX]      = 1'b1;
        m[BIT_PA]      = 1'b1;
        m[BIT_TS]      = 1'b1;
        m[BIT_TSEL_LO] = 1'b1;
        m[BIT_TSEL_HI] = ext;
        return m;
    endfunction

endpackage

// File: rtl/hpc_store.sv
// Storage for the control word.
// Only bits set in MASK get a flop; every other bit is a constant zero.
// Assumes a synchronous active-low reset that outranks the write strobe.
module hpc_store #(
    parameter int               W    = 64,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    logic [W-1:0] wr_masked;

    // Drop unimplemented bits before they reach any flop.
    always_comb wr_masked = wr_data & MASK;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_flop
            logic bit_q;
            // Hold one implemented bit; reset clears it, a strobe loads it.
            always_ff @(posedge clk) begin
                if (!rst_n)     bit_q <= 1'b0;
                else if (wr_en) bit_q <= wr_masked[i];
            end
            assign q[i] = bit_q;
        end else begin : g_zero
            assign q[i] = wr_masked[i];
        end
    end

endmodule

// File: rtl/hpc_readback.sv
// Direct-read view of the stored word.
// The two sampling enables are blanked while the buffer-owner selector is
// non-zero; every other bit is returned exactly as stored.
module hpc_readback #(
    parameter int W = 64
) (
    input  logic [W-1:0] stored,
    input  logic [1:0]   buf_owner,
    output logic [W-1:0] rd_data
);

    import hyp_prof_pkg::*;

    logic owner_taken;

    // Flag a non-zero owner selection.
    always_comb owner_taken = |buf_owner;

    // Build the read word, clearing the sampling enables when owned elsewhere.
    always_comb begin
        rd_data = stored;
        if (owner_taken) begin
            rd_data[BIT_USR] = 1'b0;
            rd_data[BIT_HYP] = 1'b0;
        end
    end

endmodule

// File: rtl/hpc_effective.sv
// Effective profiling controls derived from the stored fields.
// Forces or ignores fields according to hypervisor availability, the
// buffer-owner selector and host mode. Assumes the stored select already
// has its upper bit cleared when the extended counter is absent.
module hpc_effective #(
    parameter bit EXT_COUNTER = 1'b1
) (
    input  logic                     st_usr,
    input  logic                     st_hyp,
    input  logic                     st_cx,
    input  logic                     st_pa,
    input  logic                     st_ts,
    input  logic [1:0]               st_tsel,
    input  logic                     hyp_present,
    input  logic                     hyp_enabled,
    input  logic [1:0]               buf_owner,
    input  logic                     host_mode,
    output hyp_prof_pkg::prof_eff_t  eff
);

    import hyp_prof_pkg::*;

    logic       hyp_avail;
    logic       owner_taken;
    logic [1:0] tsel_impl;

    // The hypervisor level counts only when present and enabled here.
    always_comb hyp_avail = hyp_present & hyp_enabled;

    // A non-zero owner selector removes both sampling enables.
    always_comb owner_taken = |buf_owner;

    // Narrow the select to the implemented width.
    if (EXT_COUNTER) begin : g_wide_tsel
        always_comb tsel_impl = st_tsel;
    end else begin : g_narrow_tsel
        always_comb tsel_impl = {1'b0, st_tsel[0]};
    end

    // Resolve timestamp, address and context controls.
    always_comb begin
        eff.ts_en = st_ts;
        if (hyp_avail) begin
            eff.tsel  = tsel_impl;
            eff.pa_en = st_pa;
            eff.cx_en = st_cx;
        end else begin
            eff.tsel  = TSEL_PHYSICAL;
            eff.pa_en = 1'b1;
            eff.cx_en = 1'b0;
        end
    end

    // Resolve the two sampling enables.
    always_comb begin
        eff.hyp_samp = st_hyp & hyp_avail & ~owner_taken;
        if (owner_taken)
            eff.usr_samp = 1'b0;
        else if (hyp_avail && !host_mode)
            eff.usr_samp = 1'b0;
        else
            eff.usr_samp = st_usr;
    end

endmodule

// File: rtl/hyp_prof_ctrl.sv
// Hypervisor profiling control register, top level.
// Stores the masked control word, offers it for direct read and drives the
// effective controls used by the profiling logic. Configuration inputs are
// treated as levels; outputs are combinational from stored state and them.
module hyp_prof_ctrl #(
    parameter int REG_W       = 64,
    parameter bit EXT_COUNTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cfg_hyp_present,
    input  logic             cfg_hyp_enabled,
    input  logic [1:0]       cfg_buf_owner,
    input  logic             cfg_host_mode,
    output logic [REG_W-1:0] rd_data,
    output logic [1:0]       eff_tsel,
    output logic             eff_ts_en,
    output logic             eff_pa_en,
    output logic             eff_cx_en,
    output logic             eff_hyp_samp,
    output logic             eff_usr_samp
);

    import hyp_prof_pkg::*;

    localparam logic [63:0]      FULL_MASK = impl_mask(EXT_COUNTER);
    localparam logic [REG_W-1:0] REG_MASK  = FULL_MASK[REG_W-1:0];

    logic [REG_W-1:0] stored;
    prof_eff_t        eff;

    hpc_store #(
        .W    (REG_W),
        .MASK (REG_MASK)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (stored)
    );

    hpc_readback #(
        .W (REG_W)
    ) u_readback (
        .stored    (stored),
        .buf_owner (cfg_buf_owner),
        .rd_data   (rd_data)
    );

    hpc_effective #(
        .EXT_COUNTER (EXT_COUNTER)
    ) u_effective (
        .st_usr      (stored[BIT_USR]),
        .st_hyp      (stored[BIT_HYP]),
        .st_cx       (stored[BIT_CX]),
        .st_pa       (stored[BIT_PA]),
        .st_ts       (stored[BIT_TS]),
        .st_tsel     (stored[BIT_TSEL_HI:BIT_TSEL_LO]),
        .hyp_present (cfg_hyp_present),
        .hyp_enabled (cfg_hyp_enabled),
        .buf_owner   (cfg_buf_owner),
        .host_mode   (cfg_host_mode),
        .eff         (eff)
    );

    // Unpack the effective controls onto the output ports.
    always_comb begin
        eff_tsel     = eff.tsel;
        eff_ts_en    = eff.ts_en;
        eff_pa_en    = eff.pa_en;
        eff_cx_en    = eff.cx_en;
        eff_hyp_samp = eff.hyp_samp;
        eff_usr_samp = eff.usr_samp;
    end

endmodule

// File: rtl/hyp_prof_ctrl_chk.sv
// Assertion checker for hyp_prof_ctrl, attached to every instance by bind.
// Assumes a synchronous active-low reset held low before the first edge.
module hyp_prof_ctrl_chk #(
    parameter int REG_W       = 64,
    parameter bit EXT_COUNTER = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             cfg_hyp_present,
    input logic             cfg_hyp_enabled,
    input logic [1:0]       cfg_buf_owner,
    input logic             cfg_host_mode,
    input logic [REG_W-1:0] rd_data,
    input logic [1:0]       eff_tsel,
    input logic             eff_ts_en,
    input logic             eff_pa_en,
    input logic             eff_cx_en,
    input logic             eff_hyp_samp,
    input logic             eff_usr_samp
);

    localparam logic [5:0] HI_MASK = {EXT_COUNTER, 5'b11110};

    logic avail;
    always_comb avail = cfg_hyp_present & cfg_hyp_enabled;

    a_r1_reset_clears: assert property (@(posedge clk)
        disable iff (!rst_n) $past(!rst_n) |-> rd_data == '0);

    a_r2_reserved_zero: assert property (@(posedge clk)
        disable iff (!rst_n) rd_data[REG_W-1:8] == '0 && rd_data[2] == 1'b0);

    a_r3_write_lands: assert property (@(posedge clk)
        disable iff (!rst_n) wr_en |=> rd_data[7:2] == ($past(wr_data[7:2]) & HI_MASK));

    a_r3_hold_without_write: assert property (@(posedge clk)
        disable iff (!rst_n) !wr_en |=> $stable(rd_data[7:2]));

    a_r4_narrow_select: assert property (@(posedge clk)
        disable iff (!rst_n) !EXT_COUNTER |-> (rd_data[7] == 1'b0 && eff_tsel[1] == 1'b0));

    a_r5_tsel_forced: assert property (@(posedge clk)
        disable iff (!rst_n) !avail |-> eff_tsel == 2'b01);

    a_r6_pa_cx_forced: assert property (@(posedge clk)
        disable iff (!rst_n) !avail |-> (eff_pa_en && !eff_cx_en));

    a_r7_ts_follows: assert property (@(posedge clk)
        disable iff (!rst_n) eff_ts_en == rd_data[5]);

    a_r8_owner_blanks: assert property (@(posedge clk)
        disable iff (!rst_n) (cfg_buf_owner != 2'b00) |->
            (!eff_hyp_samp && !eff_usr_samp && rd_data[1:0] == 2'b00));

    a_r9_user_ignored: assert property (@(posedge clk)
        disable iff (!rst_n) (avail && !cfg_host_mode) |-> !eff_usr_samp);

    a_r10_hyp_ignored: assert property (@(posedge clk)
        disable iff (!rst_n) !avail |-> !eff_hyp_samp);

endmodule

bind hyp_prof_ctrl hyp_prof_ctrl_chk #(
    .REG_W       (REG_W),
    .EXT_COUNTER (EXT_COUNTER)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .cfg_hyp_present (cfg_hyp_present),
    .cfg_hyp_enabled (cfg_hyp_enabled),
    .cfg_buf_owner   (cfg_buf_owner),
    .cfg_host_mode   (cfg_host_mode),
    .rd_data         (rd_data),
    .eff_tsel        (eff_tsel),
    .eff_ts_en       (eff_ts_en),
    .eff_pa_en       (eff_pa_en),
    .eff_cx_en       (eff_cx_en),
    .eff_hyp_samp    (eff_hyp_samp),
    .eff_usr_samp    (eff_usr_samp)
);

// File: tb/hyp_prof_ctrl_tb.sv
// Sweeps every low-byte write value against all configuration combinations
// on a build with and one without the extended counter.
module hyp_prof_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        pres = 1'b1;
    logic        en = 1'b1;
    logic [1:0]  own = 2'b00;
    logic        host = 1'b1;
    logic        done = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [63:0] rd0, rd1;
    logic [1:0]  ts0, ts1;
    logic        tse0, tse1, pa0, pa1, cx0, cx1, hs0, hs1, us0, us1;

    always #10 clk = ~clk;

    hyp_prof_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_hyp_present(pres), .cfg_hyp_enabled(en), .cfg_buf_owner(own),
        .cfg_host_mode(host), .rd_data(rd0), .eff_tsel(ts0), .eff_ts_en(tse0),
        .eff_pa_en(pa0), .eff_cx_en(cx0), .eff_hyp_samp(hs0), .eff_usr_samp(us0)
    );

    hyp_prof_ctrl #(.EXT_COUNTER(1'b0)) u_dut_nx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_hyp_present(pres), .cfg_hyp_enabled(en), .cfg_buf_owner(own),
        .cfg_host_mode(host), .rd_data(rd1), .eff_tsel(ts1), .eff_ts_en(tse1),
        .eff_pa_en(pa1), .eff_cx_en(cx1), .eff_hyp_samp(hs1), .eff_usr_samp(us1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare one build's outputs with values computed from the requirements.
    task automatic check_view(input bit ext, input logic [63:0] st, input logic [63:0] rd,
                              input logic [1:0] tsel, input logic tse, input logic pa,
                              input logic cx, input logic hs, input logic us);
        bit          avail;
        logic [63:0] exp_rd;
        avail  = pres && en;
        exp_rd = st;
        if (own != 2'b00) exp_rd[1:0] = 2'b00;
        chk("R2/R3/R8 read view", rd, exp_rd);
        if (!ext) chk("R4 narrow select", {62'b0, rd[7], tsel[1]}, 64'b0);
        chk(avail ? "R7 tsel" : "R5 tsel forced", {62'b0, tsel},
            {62'b0, avail ? st[7:6] : 2'b01});
        chk("R7 ts enable", {63'b0, tse}, {63'b0, st[5]});
        chk(avail ? "R7 pa/cx" : "R6 pa/cx forced", {62'b0, pa, cx},
            {62'b0, avail ? st[4] : 1'b1, avail ? st[3] : 1'b0});
        chk(own != 2'b00 ? "R8 hyp samp" : "R10 hyp samp", {63'b0, hs},
            {63'b0, (own == 2'b00) && avail && st[1]});
        chk(own != 2'b00 ? "R8 usr samp" : "R9 usr samp", {63'b0, us},
            {63'b0, (own == 2'b00) && !(avail && !host) && st[0]});
    endtask

    initial begin : main
        logic [63:0] st0, st1;
        // R1: a write during reset is discarded
        wr_en   = 1'b1;
        wr_data = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        #1;
        chk("R1 reset read", rd0, 64'b0);
        chk("R1 reset read no-ext", rd1, 64'b0);
        chk("R1 reset effective", {57'b0, ts0, tse0, pa0, cx0, hs0, us0}, 64'b0);
        st0 = '0;
        st1 = '0;
        for (int d = 0; d < 256; d++) begin
            @(negedge clk);
            own     = 2'b00;
            wr_en   = 1'b1;
            wr_data = {~d[7:0], 48'hC3A5_5A3C_F00F, d[7:0]};
            #1;
            chk("R3 old value before edge", rd0, st0);
            st0 = {56'b0, d[7:3] , 1'b0, d[1:0]};
            st1 = {57'b0, d[6:3], 1'b0, d[1:0]};
            @(negedge clk);
            wr_en = 1'b0;
            for (int c = 0; c < 32; c++) begin
                if (c != 0) @(negedge clk);
                pres = c[0];
                en   = c[1];
                own  = c[3:2];
                host = c[4];
                #1;
                check_view(1'b1, st0, rd0, ts0, tse0, pa0, cx0, hs0, us0);
                check_view(1'b0, st1, rd1, ts1, tse1, pa1, cx1, hs1, us1);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule